// File: doc/BRIEF.md
# Timed-Window Protected Configuration Register Bank

This block holds a few small configuration registers that set up a microcontroller-style system right after reset. Each register limits how software may change it, and the limits depend on an operating-mode flag that is captured while reset is held. In normal mode some bit groups accept a single write, one register can only have bits cleared, and all of these protected writes must land inside a short window of clock cycles after reset. In special mode those limits are lifted, so a test or boot environment can rewrite the registers freely. One visibility bit can be written only once, whatever the mode.

Software reaches the bank over a simple synchronous bus: a write strobe, an address, write data and combinational read data. The current contents of every register are also driven out as ports, so that the timer, memory-protection and address-map logic elsewhere can use them.

Top module: `cfgp_bank`

## Requirements
- R1: While `rst_i` is high the bank loads its reset values: timer mask 0x00, protect register 0x1F, system options 0x0C, map register 0x01, all write-done flags clear, window counter at zero, and the visibility bit equal to `special_i`.
- R2: The mode is taken from `special_i` in the last cycle that reset is held. Later changes of `special_i` have no effect until the next reset.
- R3: The window is 64 cycles long. The clock edge k after reset release (k counted from 0) accepts a protected write when k < 64. Protected writes on later edges are ignored in normal mode.
- R4: Timer mask register (address 0): in normal mode bits [1:0] accept one write, inside the window. Bits [7:2] accept every write at any time.
- R5: Protect register (address 1): in normal mode, a write inside the window stores old AND data, so a 0 clears a bit and a 1 leaves it unchanged. Outside the window the write is ignored.
- R6: System options register (address 2): in normal mode bits 5, 4, 2, 1 and 0 accept one write, inside the window. Bits 7, 6 and 3 accept every write at any time.
- R7: Map register (address 3): in normal mode all bits accept one write, inside the window.
- R8: Visibility bit (address 4, data bit 0): the first write after reset stores it, in any mode and at any time, and later writes are ignored. The bit reads back at bit 0, with zeros above it.
- R9: In special mode, registers at addresses 0 to 3 store every written value in full, at any time and any number of times.
- R10: `rd_data_o` shows the addressed register in the same cycle, with no restriction. Addresses 5 to 7 read as zero, and writes to them change nothing.
- R11: A write inside the window to a register whose once-only group is already done leaves the protected bits unchanged but still updates the free bits of that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| special_i | input | 1 | Mode flag, captured while reset is held (1 = special) |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data of the addressed register |
| tmr_mask_o | output | 8 | Timer mask register contents |
| blk_prot_o | output | 8 | Protect register contents |
| sys_opt_o | output | 8 | System options register contents |
| mem_map_o | output | 8 | Map register contents |
| vis_o | output | 1 | Visibility bit |

## Verification
The timer mask, protect, options and map registers are each written twice in normal mode inside the window with complementary patterns. This shows whether once-only bits froze while free bits still followed the data, and whether the protect register stored a true AND. A sweep moves a single map write across the edges 60 to 67 after reset, each time after a fresh reset, which locates the window boundary exactly. Special mode gets all 256 data values on every register, repeated long after the window, so that a mode-dependent mask or a missing bit shows up. Toggling the mode flag after reset, and writing the visibility bit twice in both modes, shows whether the mode is held and whether the once-only rule for that bit is independent of the mode.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    localparam int CFG_W   = 8;
    localparam int ADDR_W  = 3;
    localparam int NREG    = 4;          // guarded byte registers
    localparam int NSLOT   = NREG + 1;   // plus visibility slot
    localparam int VIS_IDX = NREG;

    typedef logic [NREG-1:0][CFG_W-1:0] reg_vec_t;

    // index 0 timer mask, 1 protect, 2 options, 3 map
    localparam reg_vec_t RST_VALS   = {8'h01, 8'h0C, 8'h1F, 8'h00};
    localparam reg_vec_t ONCE_MASKS = {8'hFF, 8'h37, 8'h00, 8'h03};
    localparam logic [NREG-1:0] CLEAR_ONLY = 4'b0010;

    typedef struct packed {
        reg_vec_t        regs;
        logic [NREG-1:0] done;
        logic            vis;
        logic            vis_done;
        logic            special;
    } bank_state_t;
endpackage

// File: rtl/cfgp_window.sv
module cfgp_window #(
    parameter int WINDOW = 64
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic open_o
);
    localparam int CW = $clog2(WINDOW + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q < CW'(WINDOW)) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign open_o = (cnt_q < CW'(WINDOW));
endmodule

// File: rtl/cfgp_decode.sv
module cfgp_decode #(
    parameter int AW    = 3,
    parameter int SLOTS = 5
) (
    input  logic             wr_en_i,
    input  logic [AW-1:0]    addr_i,
    output logic [SLOTS-1:0] sel_o
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_sel
        assign sel_o[g] = wr_en_i && (addr_i == AW'(g));
    end
endmodule

// File: rtl/cfgp_guard.sv
module cfgp_guard #(
    parameter int         W          = 8,
    parameter logic [W-1:0] ONCE_MASK = '0,
    parameter bit         CLR_ONLY   = 1'b0
) (
    input  logic         we_i,
    input  logic         open_i,
    input  logic         special_i,
    input  logic         done_i,
    input  logic [W-1:0] old_i,
    input  logic [W-1:0] wd_i,
    output logic [W-1:0] nxt_o,
    output logic         done_set_o
);
    if (CLR_ONLY) begin : g_clear
        logic unused_done;
        assign unused_done = done_i;
        always_comb begin
            nxt_o = old_i;
            if (we_i) begin
                if (special_i) begin
                    nxt_o = wd_i;
                end else if (open_i) begin
                    nxt_o = old_i & wd_i;
                end
            end
        end
        assign done_set_o = 1'b0;
    end else begin : g_once
        logic         prot_ok;
        logic [W-1:0] prot_val;
        assign prot_ok  = special_i || (open_i && !done_i);
        assign prot_val = prot_ok ? wd_i : old_i;
        always_comb begin
            nxt_o = old_i;
            if (we_i) begin
                nxt_o = (wd_i & ~ONCE_MASK) | (prot_val & ONCE_MASK);
            end
        end
        assign done_set_o = we_i && !special_i && open_i && !done_i;
    end
endmodule

// File: rtl/cfgp_readmux.sv
module cfgp_readmux #(
    parameter int W     = 8,
    parameter int AW    = 3,
    parameter int SLOTS = 5
) (
    input  logic [AW-1:0]             addr_i,
    input  logic [SLOTS-1:0][W-1:0]   slots_i,
    output logic [W-1:0]              rd_o
);
    always_comb begin
        rd_o = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (addr_i == AW'(i)) begin
                rd_o = slots_i[i];
            end
        end
    end
endmodule

// File: rtl/cfgp_bank.sv
module cfgp_bank
    import cfgp_pkg::*;
#(
    parameter int WINDOW_CYCLES = 64
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              special_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CFG_W-1:0]  wr_data_i,
    output logic [CFG_W-1:0]  rd_data_o,
    output logic [CFG_W-1:0]  tmr_mask_o,
    output logic [CFG_W-1:0]  blk_prot_o,
    output logic [CFG_W-1:0]  sys_opt_o,
    output logic [CFG_W-1:0]  mem_map_o,
    output logic              vis_o
);
    bank_state_t st_d, st_q, st_rst;
    logic                         win_open;
    logic [NSLOT-1:0]             sel;
    reg_vec_t                     nxt;
    logic [NREG-1:0]              dset;
    logic [NSLOT-1:0][CFG_W-1:0]  slots;

    cfgp_window #(.WINDOW(WINDOW_CYCLES)) u_window (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .open_o (win_open)
    );

    cfgp_decode #(.AW(ADDR_W), .SLOTS(NSLOT)) u_decode (
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .sel_o   (sel)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_guard
        cfgp_guard #(
            .W         (CFG_W),
            .ONCE_MASK (ONCE_MASKS[g]),
            .CLR_ONLY  (CLEAR_ONLY[g])
        ) u_guard (
            .we_i       (sel[g]),
            .open_i     (win_open),
            .special_i  (st_q.special),
            .done_i     (st_q.done[g]),
            .old_i      (st_q.regs[g]),
            .wd_i       (wr_data_i),
            .nxt_o      (nxt[g]),
            .done_set_o (dset[g])
        );
        assign slots[g] = st_q.regs[g];
    end
    assign slots[VIS_IDX] = {{(CFG_W-1){1'b0}}, st_q.vis};

    // reset image: mode and visibility follow the mode pin during reset
    always_comb begin
        st_rst          = '0;
        st_rst.regs     = RST_VALS;
        st_rst.vis      = special_i;
        st_rst.special  = special_i;
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            st_d.regs[i] = nxt[i];
            st_d.done[i] = st_q.done[i] | dset[i];
        end
        if (sel[VIS_IDX] && !st_q.vis_done) begin
            st_d.vis      = wr_data_i[0];
            st_d.vis_done = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= st_rst;
        end else begin
            st_q <= st_d;
        end
    end

    cfgp_readmux #(.W(CFG_W), .AW(ADDR_W), .SLOTS(NSLOT)) u_readmux (
        .addr_i  (addr_i),
        .slots_i (slots),
        .rd_o    (rd_data_o)
    );

    assign tmr_mask_o = st_q.regs[0];
    assign blk_prot_o = st_q.regs[1];
    assign sys_opt_o  = st_q.regs[2];
    assign mem_map_o  = st_q.regs[3];
    assign vis_o      = st_q.vis;
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
    parameter int WINDOW = 64
) (
    input logic       clk_i,
    input logic       rst_i,
    input logic       special_i,
    input logic       wr_en_i,
    input logic [2:0] addr_i,
    input logic [7:0] wr_data_i,
    input logic [7:0] rd_data_o,
    input logic [7:0] tmr_mask_o,
    input logic [7:0] blk_prot_o,
    input logic [7:0] sys_opt_o,
    input logic [7:0] mem_map_o,
    input logic       vis_o
);
    localparam int CW = $clog2(WINDOW + 1);

    logic [CW-1:0] ccnt;
    logic          cmode;
    logic          vis_seen;
    logic          closed;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ccnt     <= '0;
            cmode    <= special_i;
            vis_seen <= 1'b0;
        end else begin
            if (ccnt < CW'(WINDOW)) ccnt <= ccnt + CW'(1);
            if (wr_en_i && addr_i == 3'd4) vis_seen <= 1'b1;
        end
    end
    assign closed = (ccnt >= CW'(WINDOW));

    assert_blk_no_set_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        !cmode |=> ((blk_prot_o & ~$past(blk_prot_o)) == 8'h00));

    assert_blk_frozen_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!cmode && closed) |=> $stable(blk_prot_o));

    assert_tmr_once_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (!cmode && closed) |=> $stable(tmr_mask_o[1:0]));

    assert_sys_once_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!cmode && closed) |=> $stable(sys_opt_o & 8'h37));

    assert_map_once_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!cmode && closed) |=> $stable(mem_map_o));

    assert_vis_once_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        vis_seen |=> $stable(vis_o));

    assert_special_wr_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (cmode && wr_en_i && addr_i == 3'd3) |=> (mem_map_o == $past(wr_data_i)));

    assert_idle_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        !wr_en_i |=> $stable({tmr_mask_o, blk_prot_o, sys_opt_o, mem_map_o, vis_o}));

    assert_unmapped_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (addr_i > 3'd4) |-> (rd_data_o == 8'h00));
endmodule

bind cfgp_bank cfgp_checker #(.WINDOW(WINDOW_CYCLES)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .special_i  (special_i),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wr_data_i  (wr_data_i),
    .rd_data_o  (rd_data_o),
    .tmr_mask_o (tmr_mask_o),
    .blk_prot_o (blk_prot_o),
    .sys_opt_o  (sys_opt_o),
    .mem_map_o  (mem_map_o),
    .vis_o      (vis_o)
);

// File: tb/test_cfgp_bank.sv
`timescale 1ns/1ps
module test_cfgp_bank;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       special = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rd, tmr, blk, sys, mmap;
    logic       vis;
    int         checks = 0;
    int         errors = 0;
    int         cyc = 0;

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    cfgp_bank i_cfgp_bank (
        .clk_i      (clk),
        .rst_i      (rst),
        .special_i  (special),
        .wr_en_i    (wr_en),
        .addr_i     (addr),
        .wr_data_i  (wdata),
        .rd_data_o  (rd),
        .tmr_mask_o (tmr),
        .blk_prot_o (blk),
        .sys_opt_o  (sys),
        .mem_map_o  (mmap),
        .vis_o      (vis)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        rst = 1'b1;
        special = s;
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // starts and ends at a falling edge; one rising edge captures the write
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string req);
        addr = a;
        #1;
        chk(req, rd, exp);
    endtask

    task automatic wait_idx(input int k);
        while (cyc < k) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // ---- reset values, normal mode (R1, R10)
        do_reset(1'b0);
        rd_chk(3'd0, 8'h00, "R1 timer mask reset");
        rd_chk(3'd1, 8'h1F, "R1 protect reset");
        rd_chk(3'd2, 8'h0C, "R1 options reset");
        rd_chk(3'd3, 8'h01, "R1 map reset");
        rd_chk(3'd4, 8'h00, "R1 visibility reset normal");
        for (int a = 5; a < 8; a++) rd_chk(3'(a), 8'h00, "R10 unmapped read");

        // ---- normal mode inside the window (R4 R5 R6 R7 R8 R11)
        wr(3'd0, 8'hA6); rd_chk(3'd0, 8'hA6, "R4 first timer write");
        wr(3'd0, 8'h55); rd_chk(3'd0, 8'h56, "R11 timer free bits only");
        wr(3'd1, 8'h15); rd_chk(3'd1, 8'h15, "R5 protect clear");
        wr(3'd1, 8'hFF); rd_chk(3'd1, 8'h15, "R5 protect ones keep");
        wr(3'd1, 8'h0C); rd_chk(3'd1, 8'h04, "R5 protect repeated clear");
        wr(3'd2, 8'hFF); rd_chk(3'd2, 8'hFF, "R6 first options write");
        wr(3'd2, 8'h00); rd_chk(3'd2, 8'h37, "R11 options free bits only");
        wr(3'd3, 8'h5A); rd_chk(3'd3, 8'h5A, "R7 first map write");
        wr(3'd3, 8'h00); rd_chk(3'd3, 8'h5A, "R7 map second write");
        wr(3'd4, 8'h01); rd_chk(3'd4, 8'h01, "R8 visibility first write");
        wr(3'd4, 8'h00); rd_chk(3'd4, 8'h01, "R8 visibility second write");
        wr(3'd6, 8'hFF);
        rd_chk(3'd6, 8'h00, "R10 unmapped write read");
        chk("R10 unmapped write timer", tmr, 8'h56);
        chk("R10 unmapped write protect", blk, 8'h04);
        chk("R10 unmapped write options", sys, 8'h37);
        chk("R10 unmapped write map", mmap, 8'h5A);
        chk("R10 unmapped write vis", {7'b0, vis}, 8'h01);

        // ---- window edge and mode hold (R2 R3 R4 R5 R6 R7 R8)
        do_reset(1'b0);
        special = 1'b1;
        wait_idx(63);
        wr(3'd1, 8'h0E); rd_chk(3'd1, 8'h0E, "R3 last window edge accepts");
        wr(3'd1, 8'h00); rd_chk(3'd1, 8'h0E, "R3 protect after window");
        wr(3'd1, 8'hFF); rd_chk(3'd1, 8'h0E, "R2 mode held normal");
        wr(3'd0, 8'hFF); rd_chk(3'd0, 8'hFC, "R4 timer free bits after window");
        wr(3'd2, 8'hFF); rd_chk(3'd2, 8'hCC, "R6 options after window");
        wr(3'd3, 8'h33); rd_chk(3'd3, 8'h01, "R7 map after window");
        wr(3'd4, 8'h01); rd_chk(3'd4, 8'h01, "R8 visibility late first write");

        // ---- boundary sweep of the window (R3)
        for (int k = 60; k < 68; k++) begin
            do_reset(1'b0);
            wait_idx(k);
            wr(3'd3, 8'hA5);
            rd_chk(3'd3, (k < 64) ? 8'hA5 : 8'h01, "R3 boundary sweep");
        end

        // ---- special mode (R1 R2 R8 R9)
        do_reset(1'b1);
        special = 1'b0;
        rd_chk(3'd4, 8'h01, "R1 visibility reset special");
        for (int d = 0; d < 256; d++) begin
            for (int a = 0; a < 4; a++) begin
                wr(3'(a), 8'(d));
                rd_chk(3'(a), 8'(d), "R9 special full write");
            end
        end
        wr(3'd1, 8'hE7); rd_chk(3'd1, 8'hE7, "R2 mode held special");
        wr(3'd4, 8'h00); rd_chk(3'd4, 8'h00, "R8 special visibility first");
        wr(3'd4, 8'h01); rd_chk(3'd4, 8'h00, "R8 special visibility second");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule